// File: doc/BRIEF.md
# IF Carrier Replica Generator and Mixer

This block sits right after the sampler of a satellite-navigation receiver. Each valid 2-bit intermediate-frequency sample from the radio front end is multiplied by a locally generated, 2-bit quantised sine carrier. The result is a 3-bit signed baseband sample that the correlators downstream consume. The default configuration assumes a 5.102 MHz sample clock and a carrier aliased down to 793 kHz. Exactly 793 carrier cycles fit into 5102 samples, so the replica repeats every 5102 samples.

A 13-bit sample index counts through one repeat period and returns to zero after its last value. A phase register tracks the carrier angle alongside the index, in units of one period divided by 5102. From that phase a decoder derives the 2-bit carrier level of 2.4·sin(angle), quantised to the nearest odd level. Both the counter and the phase move only when an input sample is marked valid. The product is halved, saturated and registered once, and its valid flag follows the input strobe with one cycle of delay.

Top module: `if_carrier_mixer`

## Requirements
- R1: While `rst_n` is low, and after its release until the first valid sample, `bb_valid` is 0 and `bb_sample` is 0. After reset the first valid input is mixed with carrier entry 0, whose level is +1.
- R2: `bb_valid` in each cycle equals `if_valid` of the previous cycle.
- R3: The sample index advances by one only in a cycle where `if_valid` is high. A cycle without a valid input leaves it unchanged, so the next valid input uses the same carrier entry.
- R4: After entry PERIOD-1 (5101) the index returns to 0, so the carrier sequence repeats exactly every 5102 valid samples.
- R5: Carrier entry n equals v = 2.4·sin(2π·793·n/5102). Its sign is negative exactly when v < 0, and zero counts as positive. Its magnitude is 3 when |v| ≥ 2 and 1 otherwise.
- R6: A 2-bit level code uses bit 1 for the sign (1 means negative) and bit 0 for the magnitude (0 means 1, 1 means 3). So codes 0,1,2,3 mean +1,+3,-1,-3, for both the IF input and the carrier.
- R7: `bb_sample` is the product of the two levels divided by 2, truncated toward zero and saturated to -4..+3. Products ±1 give 0, ±3 give ±1, +9 gives +3 and -9 gives -4.
- R8: In a cycle after one without a valid input, `bb_sample` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid | input | 1 | Marks `if_code` as a new sample |
| if_code | input | 2 | IF sample level code (sign bit 1, magnitude bit 0) |
| bb_valid | output | 1 | Marks `bb_sample` as newly produced |
| bb_sample | output | 3 | Signed two's-complement baseband sample |

## Verification
Two functions can fall in the same cycle: the index wrap from 5101 to 0, and a stall or restart of the valid strobe. Valid patterns with gaps of period 2 and 3 run across several wraps, so gaps land just before and just after the last table entry. A reset in the middle of a period checks that the index restarts at 0. A behavioural model holds its own index and evaluates the sine in floating point. Every clock it predicts the output flag and sample, including the held value during gaps, and compares them with the ports.

// File: rtl/ifmix_pkg.sv
package ifmix_pkg;

  // Level code: bit 1 = sign (1 negative), bit 0 = magnitude (0 -> 1, 1 -> 3)
  typedef logic [1:0] lvl_code_t;
  typedef logic signed [2:0] bb_t;

  localparam int BB_MAX = 3;
  localparam int BB_MIN = -4;

  function automatic int lvl_value(lvl_code_t c);
    int mag;
    mag = c[0] ? 3 : 1;
    return c[1] ? -mag : mag;
  endfunction

  // Product halved toward zero, then clipped to the 3-bit signed range
  function automatic bb_t mix_halve_sat(lvl_code_t a, lvl_code_t b);
    int prod;
    int half;
    prod = lvl_value(a) * lvl_value(b);
    half = prod / 2;
    if (half > BB_MAX)      half = BB_MAX;
    else if (half < BB_MIN) half = BB_MIN;
    return bb_t'(half);
  endfunction

endpackage

// File: rtl/ifmix_phase.sv
module ifmix_phase #(
  parameter int PERIOD = 5102,
  parameter int CYCLES = 793,
  parameter int CNT_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [CNT_W-1:0] phase_o
);

  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] IDX_LAST = CNT_W'(PERIOD - 1);
  localparam logic [SUM_W-1:0] STEP_S   = SUM_W'(CYCLES);
  localparam logic [SUM_W-1:0] PER_S    = SUM_W'(PERIOD);

  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] ph_q, ph_d;
  logic [SUM_W-1:0] ph_sum;
  logic             idx_wrap;

  always_comb begin
    idx_d    = idx_q;
    ph_d     = ph_q;
    idx_wrap = (idx_q == IDX_LAST);
    ph_sum   = {1'b0, ph_q} + STEP_S;
    if (adv) begin
      idx_d = idx_wrap ? '0 : idx_q + CNT_W'(1);
      ph_d  = (ph_sum >= PER_S) ? CNT_W'(ph_sum - PER_S) : ph_sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ph_q  <= '0;
    end else if (adv) begin
      idx_q <= idx_d;
      ph_q  <= ph_d;
    end
  end

  assign phase_o = ph_q;

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && idx_q == IDX_LAST) |=> (idx_q == '0)); // R4

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(idx_q) && $stable(ph_q)); // R3

  AST_PHASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == '0) |-> (ph_q == '0)); // R5

endmodule

// File: rtl/ifmix_carrier.sv
module ifmix_carrier
  import ifmix_pkg::*;
#(
  parameter int PERIOD    = 5102,
  parameter int AMP_MILLI = 2400,
  parameter int CNT_W     = 13
) (
  input  logic [CNT_W-1:0] phase_i,
  output lvl_code_t        car_o
);

  localparam real TWO_PI = 6.283185307179586;
  localparam real RATIO  = 2000.0 / real'(AMP_MILLI);
  localparam real FRAC   = $asin(RATIO) / TWO_PI;
  localparam real PER_R  = real'(PERIOD);

  // phase windows where |sin| reaches the decision level between 1 and 3
  localparam int LO_POS = int'($ceil(PER_R * FRAC));
  localparam int HI_POS = int'($floor(PER_R * (0.5 - FRAC)));
  localparam int LO_NEG = int'($ceil(PER_R * (0.5 + FRAC)));
  localparam int HI_NEG = int'($floor(PER_R * (1.0 - FRAC)));

  localparam logic [CNT_W-1:0] LO_P = CNT_W'(LO_POS);
  localparam logic [CNT_W-1:0] HI_P = CNT_W'(HI_POS);
  localparam logic [CNT_W-1:0] LO_N = CNT_W'(LO_NEG);
  localparam logic [CNT_W-1:0] HI_N = CNT_W'(HI_NEG);
  localparam logic [CNT_W:0]   PER_X = (CNT_W + 1)'(PERIOD);

  logic neg;
  logic big;

  always_comb begin
    neg   = ({phase_i, 1'b0} > PER_X);
    big   = ((phase_i >= LO_P) && (phase_i <= HI_P)) ||
            ((phase_i >= LO_N) && (phase_i <= HI_N));
    car_o = {neg, big};
  end

endmodule

// File: rtl/ifmix_mixer.sv
module ifmix_mixer
  import ifmix_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  lvl_code_t if_code_i,
  input  lvl_code_t car_code_i,
  output logic      valid_o,
  output bb_t       sample_o
);

  bb_t  sample_q, sample_d;
  logic valid_q, valid_d;

  always_comb begin
    valid_d  = en;
    sample_d = sample_q;
    if (en) sample_d = mix_halve_sat(if_code_i, car_code_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      sample_q <= '0;
    end else begin
      valid_q <= valid_d;
      if (en) sample_q <= sample_d;
    end
  end

  assign valid_o  = valid_q;
  assign sample_o = sample_q;

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> valid_o); // R2

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !valid_o); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(sample_o)); // R8

  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && if_code_i[0] && car_code_i[0] && (if_code_i[1] == car_code_i[1]))
      |=> (sample_o == 3'sd3)); // R7

  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (en && if_code_i[0] && car_code_i[0] && (if_code_i[1] != car_code_i[1]))
      |=> (sample_o == -3'sd4)); // R7

endmodule

// File: rtl/if_carrier_mixer.sv
module if_carrier_mixer
  import ifmix_pkg::*;
#(
  parameter int PERIOD    = 5102,
  parameter int CYCLES    = 793,
  parameter int AMP_MILLI = 2400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       if_valid,
  input  logic [1:0] if_code,
  output logic       bb_valid,
  output logic [2:0] bb_sample
);

  localparam int CNT_W = $clog2(PERIOD);

  logic [CNT_W-1:0] phase;
  lvl_code_t        car_code;
  bb_t              mix_out;

  ifmix_phase #(
    .PERIOD (PERIOD),
    .CYCLES (CYCLES),
    .CNT_W  (CNT_W)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (if_valid),
    .phase_o (phase)
  );

  ifmix_carrier #(
    .PERIOD    (PERIOD),
    .AMP_MILLI (AMP_MILLI),
    .CNT_W     (CNT_W)
  ) u_carrier (
    .phase_i (phase),
    .car_o   (car_code)
  );

  ifmix_mixer u_mixer (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (if_valid),
    .if_code_i  (if_code),
    .car_code_i (car_code),
    .valid_o    (bb_valid),
    .sample_o   (mix_out)
  );

  assign bb_sample = mix_out;

endmodule

// File: tb/if_carrier_mixer_bench.sv
module if_carrier_mixer_bench;

  localparam int  NPER = 5102;
  localparam int  NCYC = 793;
  localparam real PI2  = 6.283185307179586;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       if_valid = 1'b0;
  logic [1:0] if_code = 2'b00;
  logic       bb_valid;
  logic [2:0] bb_sample;

  int n_checks = 0;
  int n_errors = 0;

  if_carrier_mixer u_if_carrier_mixer (
    .clk       (clk),
    .rst_n     (rst_n),
    .if_valid  (if_valid),
    .if_code   (if_code),
    .bb_valid  (bb_valid),
    .bb_sample (bb_sample)
  );

  always #4 clk = ~clk;

  // reference model state
  int    idx_m = 0;
  logic  exp_v = 1'b0;
  int    exp_s = 0;
  string tag_s = "R1";
  bit    fresh = 1'b1;
  bit    prev_v = 1'b0;

  function automatic int code_level(logic [1:0] c);
    int m;
    m = (c[0] == 1'b1) ? 3 : 1;
    if (c[1] == 1'b1) m = -m;
    return m;
  endfunction

  function automatic int carrier_level(int n);
    int  p;
    real v;
    p = (n * NCYC) % NPER;
    v = 2.4 * $sin(PI2 * real'(p) / real'(NPER));
    if (v >= 2.0)      return 3;
    else if (v >= 0.0) return 1;
    else if (v > -2.0) return -1;
    return -3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int c;
    int a;
    int r;
    if (!rst_n) begin
      idx_m  = 0;
      exp_v  = 1'b0;
      exp_s  = 0;
      tag_s  = "R1";
      fresh  = 1'b1;
      prev_v = 1'b0;
    end else begin
      exp_v = if_valid;
      if (if_valid) begin
        c = carrier_level(idx_m);
        a = code_level(if_code);
        r = $rtoi(real'(a * c) / 2.0);
        if (r > 3) r = 3;
        if (r < -4) r = -4;
        exp_s = r;
        if (fresh)                 tag_s = "R1";
        else if (idx_m == 0)       tag_s = "R4";
        else if (!prev_v)          tag_s = "R3";
        else if (a * c == 9 || a * c == -9) tag_s = "R7";
        else if (a == 3 || a == -3) tag_s = "R6";
        else                       tag_s = "R5";
        fresh = 1'b0;
        idx_m = (idx_m + 1) % NPER;
      end else if (!fresh) begin
        tag_s = "R8";
      end
      prev_v = if_valid;
    end
  end

  task automatic compare_ports();
    n_checks++;
    if (bb_valid !== exp_v) begin
      n_errors++;
      $display("FAIL %s: bb_valid actual %b expected %b at %0t",
               (fresh && !exp_v) ? "R1" : "R2", bb_valid, exp_v, $time);
    end
    n_checks++;
    if ($signed(bb_sample) !== 3'(exp_s)) begin
      n_errors++;
      $display("FAIL %s: bb_sample actual %0d expected %0d at %0t",
               tag_s, $signed(bb_sample), exp_s, $time);
    end
  endtask

  task automatic run_mode(int cycles, int mode);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare_ports();
      case (mode)
        0: begin if_valid = 1'b1;           if_code = 2'(i % 4); end
        1: begin if_valid = (i % 3) != 0;   if_code = 2'((i / 3) % 4); end
        default: begin if_valid = (i % 2) == 0; if_code = 2'((i * 3 + 2) % 4); end
      endcase
    end
  endtask

  task automatic hold_reset(int cycles);
    @(negedge clk);
    rst_n = 1'b0;
    if_valid = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare_ports(); // R1 reset state
      if_code = 2'(i % 4);
    end
    if_valid = 1'b0;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare_ports(); // R1
    rst_n = 1'b1;
    run_mode(4, 1);
    run_mode(5300, 0);   // R4 wrap with back-to-back samples
    hold_reset(3);       // R1 mid-period reset
    run_mode(7800, 1);   // R3 gaps around the wrap
    run_mode(10600, 2);  // R8 alternating gaps
    @(negedge clk);
    compare_ports();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule